// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical page number. It reads a page directory entry and then a page table entry over a single word-wide memory port. It checks the presence, user and writable permissions of both entries. Before it reports success, it writes the accessed and dirty flags back into the entries. When a walk fails it raises a fault strobe with a three-bit error code and keeps the faulting linear address in a register that stays put until the next fault.

A requester presents a linear address together with a read/write flag. The current privilege (user or supervisor) and the rule used to combine the two user bits are sampled at the same moment, and the handshake is valid/ready. The walker serves one request at a time and ends every request with a single-cycle `done` or `fault` pulse. When paging is switched off the linear page passes through unchanged and memory is never touched.

An entry is a 32-bit word with these fields. Bit 0 is present. Bit 1 is writable. Bit 2 allows user access. Bit 5 is accessed. Bit 6 is dirty. Bits 31:12 hold a frame number.

Top module: `pgwalk_top`

## Requirements
- R1: The directory entry is read from word address {dir_base[31:12], 12'b0} + 4*lin[31:22]. The low 12 bits of dir_base have no effect on this address.
- R2: The table entry is read from word address {directory entry[31:12], 12'b0} + 4*lin[21:12].
- R3: A clear present bit (bit 0) in either entry ends the walk with a fault whose code is {user, write, 0}. Nothing is written to memory.
- R4: `fault_addr` takes the linear address of each faulting request. It keeps that value through any later successful walks.
- R5: With `strict_user`=0, a user access is refused only when the user bits (bit 2) of both entries are 0.
- R6: With `strict_user`=1, a user access is refused when either user bit is 0.
- R7: A user write is refused when either writable bit (bit 1) is 0. A supervisor access is never refused on permissions. A refusal gives fault code {1, write, 1}.
- R8: After the permission checks pass, a directory entry whose accessed bit (bit 5) is clear is written back once with that bit set. If the bit is already set, the entry is not written.
- R9: A table entry is written back in one write when its accessed bit is clear, or when the access is a write and its dirty bit (bit 6) is clear. The written word has accessed set and, for a write, dirty set. Otherwise the entry is not written.
- R10: With `paging_en`=0, the request completes one cycle after acceptance with `phys_page`=lin[31:12] and makes no memory request.
- R11: `req_ready` is high only while the walker is idle. Each request ends with exactly one one-cycle pulse of either `done` or `fault`, never both.
- R12: Once raised, `mem_req` stays high with a stable address and write flag until `mem_ack`.
- R13: A successful walk returns the table entry's frame field as `phys_page`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| paging_en | input | 1 | Translation enabled |
| dir_base | input | 32 | Directory base register |
| user | input | 1 | Request made at user privilege |
| strict_user | input | 1 | 1: either user bit clear refuses; 0: both must be clear |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_lin | input | 32 | Linear address |
| req_write | input | 1 | Request is a write |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| done | output | 1 | Successful completion pulse |
| phys_page | output | 20 | Translated physical page |
| fault | output | 1 | Page fault pulse |
| fault_code | output | 3 | Fault error code |
| fault_addr | output | 32 | Last faulting linear address |

## Verification
The hardest case to reach is a walk that needs both write-backs, directory first and table second, while the memory stretches every access over a random number of wait cycles. The directory must carry a clear accessed bit. The table entry must need an update. The permission checks must still pass. The stimulus places fresh entries at the addresses each request will compute, biases the present bits high, and draws the flag bits at random, so every mix of write-back counts comes up many times under variable latency. A second hard case is `fault_addr` holding its value across successful walks. It is checked after every vector against the last faulting address the bench saw.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
   localparam int ENT_P = 0;
   localparam int ENT_W = 1;
   localparam int ENT_U = 2;
   localparam int ENT_A = 5;
   localparam int ENT_D = 6;
   localparam int ERR_W = 3;

   typedef enum logic [2:0] {
      S_IDLE,
      S_RDDIR,
      S_RDTBL,
      S_CHK,
      S_WRDIR,
      S_WRTBL
   } walk_st_t;
endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 12,
   parameter int IDX_W  = 10
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] lin,
   input  logic [ADDR_W-1:0] dir_ent,
   output logic [ADDR_W-1:0] dir_addr,
   output logic [ADDR_W-1:0] tbl_addr
);
   localparam int PPN_W = ADDR_W - OFS_W;

   logic [IDX_W-1:0] dir_idx;
   logic [IDX_W-1:0] tbl_idx;

   always_comb begin
      dir_idx  = lin[ADDR_W-1 -: IDX_W];
      tbl_idx  = lin[OFS_W+IDX_W-1 -: IDX_W];
      dir_addr = {base[ADDR_W-1 -: PPN_W], {OFS_W{1'b0}}}
                 + (ADDR_W'(dir_idx) << 2);
      tbl_addr = {dir_ent[ADDR_W-1 -: PPN_W], {OFS_W{1'b0}}}
                 + (ADDR_W'(tbl_idx) << 2);
   end
endmodule

// File: rtl/pgwalk_perm.sv
module pgwalk_perm
   import pgwalk_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] dir_ent,
   input  logic [ADDR_W-1:0] tbl_ent,
   input  logic              usr,
   input  logic              wr,
   input  logic              strict,
   output logic              deny,
   output logic              dir_wb,
   output logic              tbl_wb,
   output logic [ADDR_W-1:0] dir_new,
   output logic [ADDR_W-1:0] tbl_new
);
   logic u_bad;
   logic w_bad;

   always_comb begin
      if (strict)
         u_bad = !dir_ent[ENT_U] || !tbl_ent[ENT_U];
      else
         u_bad = !dir_ent[ENT_U] && !tbl_ent[ENT_U];
      w_bad = wr && (!dir_ent[ENT_W] || !tbl_ent[ENT_W]);
      deny  = usr && (u_bad || w_bad);

      dir_new        = dir_ent;
      dir_new[ENT_A] = 1'b1;
      dir_wb         = !dir_ent[ENT_A];

      tbl_new        = tbl_ent;
      tbl_new[ENT_A] = 1'b1;
      if (wr) tbl_new[ENT_D] = 1'b1;
      tbl_wb         = !tbl_ent[ENT_A] || (wr && !tbl_ent[ENT_D]);
   end
endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
   import pgwalk_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    paging_en,
   input  logic                    user,
   input  logic                    strict_user,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [ADDR_W-1:0]       req_lin,
   input  logic                    req_write,
   output logic                    mem_req,
   output logic                    mem_we,
   output logic [ADDR_W-1:0]       mem_addr,
   output logic [ADDR_W-1:0]       mem_wdata,
   input  logic [ADDR_W-1:0]       mem_rdata,
   input  logic                    mem_ack,
   input  logic [ADDR_W-1:0]       dir_addr,
   input  logic [ADDR_W-1:0]       tbl_addr,
   input  logic                    deny,
   input  logic                    dir_wb,
   input  logic                    tbl_wb,
   input  logic [ADDR_W-1:0]       dir_new,
   input  logic [ADDR_W-1:0]       tbl_new,
   output logic [ADDR_W-1:0]       lin_q,
   output logic [ADDR_W-1:0]       dir_q,
   output logic [ADDR_W-1:0]       tbl_q,
   output logic                    wr_q,
   output logic                    usr_q,
   output logic                    strict_q,
   output logic                    done,
   output logic [ADDR_W-OFS_W-1:0] phys_page,
   output logic                    fault,
   output logic [ERR_W-1:0]        fault_code,
   output logic [ADDR_W-1:0]       fault_addr
);
   walk_st_t st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= S_IDLE;
         lin_q      <= '0;
         dir_q      <= '0;
         tbl_q      <= '0;
         wr_q       <= 1'b0;
         usr_q      <= 1'b0;
         strict_q   <= 1'b0;
         done       <= 1'b0;
         fault      <= 1'b0;
         fault_code <= '0;
         fault_addr <= '0;
         phys_page  <= '0;
      end else begin
         done  <= 1'b0;
         fault <= 1'b0;
         unique case (st)
            S_IDLE: if (req_valid) begin
               lin_q    <= req_lin;
               wr_q     <= req_write;
               usr_q    <= user;
               strict_q <= strict_user;
               if (paging_en) st <= S_RDDIR;
               else begin
                  done      <= 1'b1;
                  phys_page <= req_lin[ADDR_W-1:OFS_W];
               end
            end
            S_RDDIR: if (mem_ack) begin
               dir_q <= mem_rdata;
               if (!mem_rdata[ENT_P]) begin
                  fault      <= 1'b1;
                  fault_code <= {usr_q, wr_q, 1'b0};
                  fault_addr <= lin_q;
                  st         <= S_IDLE;
               end else st <= S_RDTBL;
            end
            S_RDTBL: if (mem_ack) begin
               tbl_q <= mem_rdata;
               if (!mem_rdata[ENT_P]) begin
                  fault      <= 1'b1;
                  fault_code <= {usr_q, wr_q, 1'b0};
                  fault_addr <= lin_q;
                  st         <= S_IDLE;
               end else st <= S_CHK;
            end
            S_CHK: begin
               if (deny) begin
                  fault      <= 1'b1;
                  fault_code <= {1'b1, wr_q, 1'b1};
                  fault_addr <= lin_q;
                  st         <= S_IDLE;
               end else if (dir_wb) st <= S_WRDIR;
               else if (tbl_wb) st <= S_WRTBL;
               else begin
                  done      <= 1'b1;
                  phys_page <= tbl_q[ADDR_W-1:OFS_W];
                  st        <= S_IDLE;
               end
            end
            S_WRDIR: if (mem_ack) begin
               if (tbl_wb) st <= S_WRTBL;
               else begin
                  done      <= 1'b1;
                  phys_page <= tbl_q[ADDR_W-1:OFS_W];
                  st        <= S_IDLE;
               end
            end
            S_WRTBL: if (mem_ack) begin
               done      <= 1'b1;
               phys_page <= tbl_q[ADDR_W-1:OFS_W];
               st        <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      req_ready = (st == S_IDLE);
      mem_req   = (st == S_RDDIR) || (st == S_RDTBL) ||
                  (st == S_WRDIR) || (st == S_WRTBL);
      mem_we    = (st == S_WRDIR) || (st == S_WRTBL);
      mem_addr  = ((st == S_RDDIR) || (st == S_WRDIR)) ? dir_addr : tbl_addr;
      mem_wdata = (st == S_WRDIR) ? dir_new : tbl_new;
   end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
   import pgwalk_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 12,
   parameter int IDX_W  = 10
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    paging_en,
   input  logic [ADDR_W-1:0]       dir_base,
   input  logic                    user,
   input  logic                    strict_user,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [ADDR_W-1:0]       req_lin,
   input  logic                    req_write,
   output logic                    mem_req,
   output logic                    mem_we,
   output logic [ADDR_W-1:0]       mem_addr,
   output logic [ADDR_W-1:0]       mem_wdata,
   input  logic [ADDR_W-1:0]       mem_rdata,
   input  logic                    mem_ack,
   output logic                    done,
   output logic [ADDR_W-OFS_W-1:0] phys_page,
   output logic                    fault,
   output logic [ERR_W-1:0]        fault_code,
   output logic [ADDR_W-1:0]       fault_addr
);
   if (ADDR_W != OFS_W + 2 * IDX_W) begin : g_bad_split
      $error("pgwalk_top: address split does not add up");
   end
   if (OFS_W <= ENT_D) begin : g_bad_ofs
      $error("pgwalk_top: offset too narrow for entry flags");
   end

   logic [ADDR_W-1:0] lin_q, dir_q, tbl_q;
   logic [ADDR_W-1:0] dir_addr, tbl_addr, dir_new, tbl_new;
   logic              wr_q, usr_q, strict_q;
   logic              deny, dir_wb, tbl_wb;

   pgwalk_addr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) addr_i (
      .base(dir_base), .lin(lin_q), .dir_ent(dir_q),
      .dir_addr(dir_addr), .tbl_addr(tbl_addr)
   );

   pgwalk_perm #(.ADDR_W(ADDR_W)) perm_i (
      .dir_ent(dir_q), .tbl_ent(tbl_q), .usr(usr_q), .wr(wr_q),
      .strict(strict_q), .deny(deny), .dir_wb(dir_wb), .tbl_wb(tbl_wb),
      .dir_new(dir_new), .tbl_new(tbl_new)
   );

   pgwalk_ctrl #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .paging_en(paging_en), .user(user),
      .strict_user(strict_user), .req_valid(req_valid),
      .req_ready(req_ready), .req_lin(req_lin), .req_write(req_write),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .dir_addr(dir_addr), .tbl_addr(tbl_addr), .deny(deny),
      .dir_wb(dir_wb), .tbl_wb(tbl_wb), .dir_new(dir_new),
      .tbl_new(tbl_new), .lin_q(lin_q), .dir_q(dir_q), .tbl_q(tbl_q),
      .wr_q(wr_q), .usr_q(usr_q), .strict_q(strict_q), .done(done),
      .phys_page(phys_page), .fault(fault), .fault_code(fault_code),
      .fault_addr(fault_addr)
   );
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              paging_en,
   input logic              req_valid,
   input logic              req_ready,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [ADDR_W-1:0] mem_wdata,
   input logic              mem_ack,
   input logic              done,
   input logic              fault
);
   // R11: completion strobes never together
   p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fault));

   // R11: a completing walker is idle again
   p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (done || fault) |-> req_ready);

   // R12: request held with stable address until acknowledged
   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R10: untranslated request finishes next cycle without memory
   p_nomem_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !paging_en) |=> (done && !mem_req));

   // R8 and R9: every write-back carries the accessed flag
   p_wrset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wdata[5]);
endmodule

bind pgwalk_top pgwalk_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .paging_en(paging_en), .req_valid(req_valid),
   .req_ready(req_ready), .mem_req(mem_req), .mem_we(mem_we),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
   .done(done), .fault(fault)
);

// File: tb/pgwalk_top_tb_top.sv
module pgwalk_top_tb_top;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n, paging_en, user, strict_user, req_valid, req_write;
   logic [31:0] dir_base, req_lin;
   logic        req_ready, mem_req, mem_we, done, fault;
   logic [31:0] mem_addr, mem_wdata, fault_addr;
   logic [19:0] phys_page;
   logic [2:0]  fault_code;
   logic        ack_r = 1'b0;
   logic [31:0] rd_r = '0;

   pgwalk_top dut_i (
      .clk(clk), .rst_n(rst_n), .paging_en(paging_en), .dir_base(dir_base),
      .user(user), .strict_user(strict_user), .req_valid(req_valid),
      .req_ready(req_ready), .req_lin(req_lin), .req_write(req_write),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(rd_r), .mem_ack(ack_r),
      .done(done), .phys_page(phys_page), .fault(fault),
      .fault_code(fault_code), .fault_addr(fault_addr)
   );

   logic [31:0] mem [0:4095];
   int lat = 0;
   int wr_cnt = 0;
   int req_cyc = 0;
   int n_vec = 0;
   int n_bad = 0;
   int cyc = 0;
   bit finished = 0;
   logic [31:0] last_fa = '0;

   always @(posedge clk) begin
      cyc++;
      if (mem_req) req_cyc++;
      if (mem_req && mem_we && ack_r) wr_cnt++;
      if (mem_req && !ack_r) begin
         if (lat == 0) begin
            ack_r <= 1'b1;
            rd_r  <= mem[mem_addr[13:2]];
            if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
         end else lat <= lat - 1;
      end else begin
         ack_r <= 1'b0;
         lat   <= int'($urandom % 4);
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic walk(bit pg, bit wr, bit us, bit st, logic [31:0] lin,
                       logic [11:0] base_lo, int tpg,
                       logic [31:0] de_raw, logic [31:0] te_raw);
      logic [31:0] de, te, de_x, te_x;
      int di, ti, w0, r0, wait_n, exp_w;
      bit u_bad, w_bad, exp_f;
      logic [2:0] exp_c;
      string tg;
      di = int'(lin[31:22]);
      ti = tpg * 1024 + int'(lin[21:12]);
      de = {18'h0, 2'(tpg), de_raw[11:0]};
      te = te_raw;
      mem[di] = de;
      mem[ti] = te;
      @(negedge clk);
      paging_en = pg; req_write = wr; user = us; strict_user = st;
      req_lin = lin; dir_base = {20'h0, base_lo}; req_valid = 1'b1;
      w0 = wr_cnt; r0 = req_cyc;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      wait_n = 0;
      while (!(done || fault) && wait_n < 300) begin
         @(negedge clk);
         wait_n++;
      end
      if (wait_n >= 300) begin
         chk("R11 watchdog", 32'd1, 32'd0);
         return;
      end
      chk("R11 exclusive strobes", 32'(done && fault), 32'd0);
      u_bad = st ? (!de[2] || !te[2]) : (!de[2] && !te[2]);
      w_bad = wr && (!de[1] || !te[1]);
      exp_f = 0; exp_c = 3'd0; exp_w = 0;
      de_x = de; te_x = te; tg = "R13";
      if (!pg) begin
         tg = "R10";
         chk("R10 no memory request", 32'(req_cyc - r0), 32'd0);
      end else if (!de[0] || !te[0]) begin
         exp_f = 1; exp_c = {us, wr, 1'b0}; tg = "R3";
      end else if (us && (u_bad || w_bad)) begin
         exp_f = 1; exp_c = {1'b1, wr, 1'b1};
         tg = w_bad ? "R7" : (st ? "R6" : "R5");
      end else begin
         de_x = de | 32'h20;
         te_x = te | 32'h20 | (wr ? 32'h40 : 32'h0);
         exp_w = int'(de_x != de) + int'(te_x != te);
         tg = us ? (st ? "R6 R7 R13" : "R5 R7 R13") : "R7 R13";
      end
      chk({tg, " fault"}, 32'(fault), 32'(exp_f));
      chk({tg, " done"}, 32'(done), 32'(!exp_f));
      if (exp_f) begin
         chk({tg, " code"}, 32'(fault_code), 32'(exp_c));
         chk("R4 fault address", fault_addr, lin);
         last_fa = lin;
      end else begin
         chk({tg, " R1 R2 phys page"}, 32'(phys_page),
             pg ? 32'(te[31:12]) : 32'(lin[31:12]));
         chk("R4 fault address held", fault_addr, last_fa);
      end
      if (pg) begin
         chk("R8 directory entry", mem[di], de_x);
         chk("R9 table entry", mem[ti], te_x);
         chk("R8 R9 write count", 32'(wr_cnt - w0), 32'(exp_w));
      end
      @(negedge clk);
      chk("R11 one-cycle pulse", 32'({done, fault}), 32'd0);
      chk("R11 ready idle", 32'(req_ready), 32'd1);
   endtask

   initial begin
      void'($urandom(32'd7321));
      rst_n = 1'b0; paging_en = 1'b0; user = 1'b0; strict_user = 1'b0;
      req_valid = 1'b0; req_write = 1'b0; dir_base = '0; req_lin = '0;
      repeat (3) @(negedge clk);
      chk("R11 reset ready", 32'(req_ready), 32'd1);
      chk("R11 reset strobes", 32'({done, fault, mem_req}), 32'd0);
      chk("R4 reset fault address", fault_addr, 32'd0);
      rst_n = 1'b1;
      // R10 pass-through
      walk(0, 1, 1, 0, 32'hDEAD_B123, 12'h0, 1, 32'h0, 32'h0);
      // R3 directory not present, then table not present
      walk(1, 1, 1, 0, 32'h1234_5678, 12'hABC, 2, 32'h066, 32'h067);
      walk(1, 0, 0, 0, 32'h8765_4321, 12'h0, 3, 32'h067, 32'h066);
      // R5: one user bit set is enough; R6: refused
      walk(1, 0, 1, 0, 32'h4000_1000, 12'h0, 1, 32'h003, 32'hAAAA_5065);
      walk(1, 0, 1, 1, 32'h4000_1000, 12'h0, 1, 32'h003, 32'hAAAA_5065);
      // R7 supervisor write to read-only page is allowed
      walk(1, 1, 0, 1, 32'h0040_2000, 12'h0, 2, 32'h025, 32'h1234_5005);
      // R9 nothing to update: zero writes
      walk(1, 1, 1, 1, 32'hFFC0_3000, 12'h0, 3, 32'h027, 32'h5555_5067);
      for (int i = 0; i < 700; i++) begin
         walk(($urandom % 8) != 0, $urandom % 2 == 1, $urandom % 2 == 1,
              $urandom % 2 == 1, $urandom, 12'($urandom),
              1 + int'($urandom % 3),
              ($urandom & 32'hFFFF_FFFE) | 32'(($urandom % 8) != 0),
              ($urandom & 32'hFFFF_FFFE) | 32'(($urandom % 8) != 0));
      end
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   always @(posedge clk) begin
      if (cyc > 190000 && !finished) begin
         finished = 1;
         n_vec++;
         n_bad++;
         $display("FAIL R11 global watchdog: actual %0d expected below 190000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule